// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM that is 16 bits wide. The host presents one request at a time through a valid/ready handshake. Each request carries a read/write flag, a word address, write data and a two-bit lane mask. The controller turns each accepted request into a complete bus cycle on the memory pins. For a read, it returns the sampled word on a one-cycle response strobe. Every timing limit of the memory is converted at elaboration into a whole number of clock cycles by ceiling division of the nanosecond limit by `CLK_PERIOD_NS`. The limits come from a two-way speed-grade select.

A Moore state machine runs the sequence. It has eight states. ST_IDLE is the only state that takes requests. A read goes ST_RD_SETUP -> ST_RD_WAIT -> ST_RD_DONE -> ST_IDLE. A write goes ST_WR_SETUP -> ST_WR_PULSE -> ST_WR_HOLD -> ST_IDLE. If a read was the last bus cycle, a write is routed ST_IDLE -> ST_TURN -> ST_WR_SETUP so that the memory has released the data bus before the controller drives it. ST_RD_WAIT, ST_WR_PULSE and ST_TURN each last a counted number of cycles. Each of the other states lasts one cycle.

With the grade's limits in cycles (address-to-data cA, output-enable-to-data cO, write-enable pulse cP, data setup cS, address-to-write-end cW, write cycle cC, output-release cZ), the phase lengths are:
- N_RD = max(cO, cA-1, 1)
- N_PW = max(cP, cS-1, cW-1, cC-2, 1)
- N_TA = max(cZ, 1)

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready`=1, `rsp_valid`=0, chip deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_oe_n`=1, `sram_we_n`=1, both lane enables high, `sram_dq_oe`=0.
- R2: A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the sequence returns to ST_IDLE. A request raised and dropped while the controller is busy has no effect on memory.
- R3: For a read, the address stays stable while the output enable is low. `rsp_valid` is high for exactly one cycle, 2+N_RD cycles after the accepting edge. By the sampling edge the address has been stable for at least cA cycles and the output enable low for at least cO cycles. `req_ready` returns 3+N_RD cycles after acceptance.
- R4: Mask bit 0 enables bits 7:0 (`sram_ble_n` low) and bit 1 enables bits 15:8 (`sram_bhe_n` low). In read data, lanes whose mask bit is 0 are returned as zero.
- R5: During a write, the write enable is low for N_PW cycles (at least cP). Data and address are driven and unchanged for at least cS and cW cycles respectively before the write enable rises.
- R6: The write enable returns high while data is still driven, the address unchanged and the chip selected. The bus is released one cycle later.
- R7: A write updates only the lanes whose mask bit is 1. A write with mask 0 leaves the word unchanged.
- R8: A write whose preceding bus cycle was a read passes through ST_TURN for N_TA cycles with the bus released. `req_ready` returns N_PW+N_TA+3 cycles after acceptance; for any other write it returns after N_PW+3. The controller never drives data while the memory drives, nor within cZ cycles after the memory stops.
- R9: The output enable and write enable are never low together. Data is never driven while the output enable is low.
- R10: While `req_ready` is 1, the chip is deselected, both strobes are high and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_ble_n | output | 1 | Active-low low-lane enable |
| sram_bhe_n | output | 1 | Active-low high-lane enable |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_out | output | DATA_W | Data to memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DATA_W | Data from memory |

## Verification
Two events can land on one clock edge: a read's sequence returns to idle, and a write request that the host has kept pending is accepted. The turnaround decision must then come from the read just finished. The bench provokes this by presenting each next request on the very cycle `req_ready` is seen. Every write therefore follows its predecessor with no idle gap, after reads and after writes alike. The release-to-ready latency is judged against N_PW+3 or N_PW+N_TA+3, as computed in the bench. A pin-level memory model counts setup, pulse and release cycles and returns a poison word on early sampling.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } ctl_state_e;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int lim_ns, input int per_ns);
        return (lim_ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [1:0]        lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int LANE_W = DATA_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= cap;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (cap) begin
                rsp_rdata[g*LANE_W +: LANE_W] <=
                    lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter bit FAST_GRADE    = 1'b1,
    parameter int ADDR_W        = 20,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_bmask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ble_n,
    output logic              sram_bhe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    // Grade limits in ns
    localparam int T_AA   = FAST_GRADE ? 10 : 15;
    localparam int T_DOE  = FAST_GRADE ? 5  : 8;
    localparam int T_PWE  = FAST_GRADE ? 7  : 12;
    localparam int T_SD   = FAST_GRADE ? 5  : 8;
    localparam int T_AW   = FAST_GRADE ? 7  : 12;
    localparam int T_WC   = FAST_GRADE ? 10 : 15;
    localparam int T_HZOE = FAST_GRADE ? 5  : 8;

    localparam int C_AA   = ns_to_cyc(T_AA,   CLK_PERIOD_NS);
    localparam int C_DOE  = ns_to_cyc(T_DOE,  CLK_PERIOD_NS);
    localparam int C_PWE  = ns_to_cyc(T_PWE,  CLK_PERIOD_NS);
    localparam int C_SD   = ns_to_cyc(T_SD,   CLK_PERIOD_NS);
    localparam int C_AW   = ns_to_cyc(T_AW,   CLK_PERIOD_NS);
    localparam int C_WC   = ns_to_cyc(T_WC,   CLK_PERIOD_NS);
    localparam int C_HZOE = ns_to_cyc(T_HZOE, CLK_PERIOD_NS);

    // Setup states supply one cycle of address/data lead already.
    localparam int N_RD = max2(max2(C_DOE, C_AA - 1), 1);
    localparam int N_PW = max2(max2(C_PWE, C_SD - 1),
                               max2(max2(C_AW - 1, C_WC - 2), 1));
    localparam int N_TA = max2(C_HZOE, 1);
    localparam int CNT_W = $clog2(max2(max2(N_RD, N_PW), N_TA)) + 1;

    ctl_state_e        st_q, st_n;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        mask_q;
    logic              rd_recent_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic              sel;
    logic              cap;

    assign accept = req_valid && (st_q == ST_IDLE);

    // Next-state decision
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:     if (req_valid) begin
                             if (!req_write)      st_n = ST_RD_SETUP;
                             else if (rd_recent_q) st_n = ST_TURN;
                             else                  st_n = ST_WR_SETUP;
                         end
            ST_RD_SETUP: st_n = ST_RD_WAIT;
            ST_RD_WAIT:  if (tmr_expired) st_n = ST_RD_DONE;
            ST_RD_DONE:  st_n = ST_IDLE;
            ST_TURN:     if (tmr_expired) st_n = ST_WR_SETUP;
            ST_WR_SETUP: st_n = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_expired) st_n = ST_WR_HOLD;
            ST_WR_HOLD:  st_n = ST_IDLE;
            default:     st_n = ST_IDLE;
        endcase
    end

    // Phase timer load on entry to a counted state
    always_comb begin
        tmr_load = (st_n != st_q);
        tmr_val  = '0;
        unique case (st_n)
            ST_RD_WAIT:  tmr_val = CNT_W'(N_RD - 1);
            ST_WR_PULSE: tmr_val = CNT_W'(N_PW - 1);
            ST_TURN:     tmr_val = CNT_W'(N_TA - 1);
            default:     tmr_load = 1'b0;
        endcase
    end

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            addr_q      <= '0;
            wdata_q     <= '0;
            mask_q      <= '0;
            rd_recent_q <= 1'b0;
        end else begin
            st_q <= st_n;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_bmask;
            end
            if (st_q == ST_RD_DONE)       rd_recent_q <= 1'b1;
            else if (st_q == ST_WR_SETUP) rd_recent_q <= 1'b0;
        end
    end

    // Pin decode from the current state
    always_comb begin
        sel = 1'b0;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (st_q)
            ST_RD_SETUP: sel = 1'b1;
            ST_RD_WAIT:  begin sel = 1'b1; sram_oe_n = 1'b0; end
            ST_WR_SETUP: begin sel = 1'b1; sram_dq_oe = 1'b1; end
            ST_WR_PULSE: begin sel = 1'b1; sram_dq_oe = 1'b1; sram_we_n = 1'b0; end
            ST_WR_HOLD:  begin sel = 1'b1; sram_dq_oe = 1'b1; end
            default:     sel = 1'b0;
        endcase
        req_ready   = (st_q == ST_IDLE);
        sram_ce1_n  = !sel;
        sram_ce2    = sel;
        sram_ble_n  = !(sel && mask_q[0]);
        sram_bhe_n  = !(sel && mask_q[1]);
        sram_addr   = addr_q;
        sram_dq_out = wdata_q;
        cap         = (st_q == ST_RD_WAIT) && tmr_expired;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .lane_en   (mask_q),
        .dq_in     (sram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    a_r9_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> sram_we_n);

    a_r6_we_rise_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce1_n && sram_ce2 && $stable(sram_addr)));

    a_r5_we_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

    a_r5_we_low_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && !sram_ce1_n && sram_ce2));

    a_r3_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r3_addr_stable_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .sram_ce1_n  (sram_ce1_n),
    .sram_ce2    (sram_ce2),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
    localparam int PER_NS = 4;
    localparam int AW = 20;
    localparam int DW = 16;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Slow-grade limits, converted in the bench
    localparam int E_AA  = cdiv(15, PER_NS);
    localparam int E_DOE = cdiv(8,  PER_NS);
    localparam int E_PWE = cdiv(12, PER_NS);
    localparam int E_SD  = cdiv(8,  PER_NS);
    localparam int E_AW  = cdiv(12, PER_NS);
    localparam int E_WC  = cdiv(15, PER_NS);
    localparam int E_HZ  = cdiv(8,  PER_NS);
    localparam int E_RD  = mx(mx(E_DOE, E_AA - 1), 1);
    localparam int E_PW  = mx(mx(E_PWE, E_SD - 1), mx(mx(E_AW - 1, E_WC - 2), 1));
    localparam int E_TA  = mx(E_HZ, 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_bmask = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_ble_n, sram_bhe_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic          sram_dq_oe;
    logic [DW-1:0] sram_dq_in = 16'hBAD1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit last_rd = 1'b0;

    logic [DW-1:0] shadow [int];
    logic [DW-1:0] mdl    [int];

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .CLK_PERIOD_NS(PER_NS), .FAST_GRADE(1'b0), .ADDR_W(AW), .DATA_W(DW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ble_n(sram_ble_n), .sram_bhe_n(sram_bhe_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] get_word(input bit from_model, input int k);
        if (from_model) return mdl.exists(k) ? mdl[k] : '0;
        return shadow.exists(k) ? shadow[k] : '0;
    endfunction

    function automatic logic [DW-1:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // Pin-level memory model with timing counters
    int a_cnt = 0, oe_cnt = 0, we_cnt = 0, d_cnt = 0, hz_gap = 1000;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq = '0;
    logic p_sel = 1'b0, p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [1:0] p_be_n = 2'b11;

    always @(negedge clk) begin
        logic sel, mdrv;
        logic [DW-1:0] w;
        if (!rst_n) begin
            a_cnt = 0; oe_cnt = 0; we_cnt = 0; d_cnt = 0; hz_gap = 1000;
            p_sel = 1'b0; p_we_n = 1'b1; p_dq_oe = 1'b0;
            sram_dq_in = 16'hBAD1;
        end else begin
            sel  = !sram_ce1_n && sram_ce2;
            mdrv = sel && !sram_oe_n && sram_we_n && (!sram_ble_n || !sram_bhe_n);
            if (sram_dq_oe)
                chk(!mdrv && hz_gap >= E_HZ, "R8 data driven into memory output", hz_gap, E_HZ);
            if (!p_we_n && sram_we_n) begin
                chk(we_cnt >= E_PWE, "R5 write pulse width", we_cnt, E_PWE);
                chk(d_cnt >= E_SD, "R5 data setup", d_cnt, E_SD);
                chk(a_cnt >= E_AW, "R5 address setup", a_cnt, E_AW);
                chk(sram_dq_oe && sel && sram_addr == p_addr && sram_dq_out == p_dq,
                    "R6 hold at write end", int'(sram_dq_oe), 1);
                w = get_word(1'b1, int'(p_addr));
                if (!p_be_n[0]) w[7:0]  = p_dq[7:0];
                if (!p_be_n[1]) w[15:8] = p_dq[15:8];
                mdl[int'(p_addr)] = w;
            end
            a_cnt  = sel ? ((p_sel && sram_addr == p_addr) ? a_cnt + 1 : 1) : 0;
            oe_cnt = (sel && !sram_oe_n) ? oe_cnt + 1 : 0;
            we_cnt = (sel && !sram_we_n) ? we_cnt + 1 : 0;
            d_cnt  = sram_dq_oe ? ((p_dq_oe && sram_dq_out == p_dq) ? d_cnt + 1 : 1) : 0;
            hz_gap = mdrv ? 0 : ((hz_gap < 1000) ? hz_gap + 1 : hz_gap);
            p_sel = sel; p_we_n = sram_we_n; p_dq_oe = sram_dq_oe;
            p_addr = sram_addr; p_dq = sram_dq_out; p_be_n = {sram_bhe_n, sram_ble_n};
            sram_dq_in = (mdrv && a_cnt >= E_AA && oe_cnt >= E_DOE)
                       ? get_word(1'b1, int'(sram_addr)) : 16'hBAD1;
        end
    end

    // Called at a negedge where req_ready is 1; returns at the negedge where ready is back.
    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] m, input bit intrude, input logic [AW-1:0] ia);
        int n = 0;
        int rsp_at = 0;
        int rsp_cnt = 0;
        int exp_done;
        logic [DW-1:0] got = '0;
        logic [DW-1:0] w;
        chk(req_ready == 1'b1, "R2 ready before request", int'(req_ready), 1);
        exp_done = wr ? (E_PW + 3 + (last_rd ? E_TA : 0)) : (E_RD + 3);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
                if (intrude) begin
                    req_valid = 1'b1; req_write = 1'b1; req_addr = ia;
                    req_wdata = 16'h0BAD; req_bmask = 2'b11;
                end
            end
            if (n == 2) req_valid = 1'b0;
            if (rsp_valid) begin
                rsp_cnt++;
                if (rsp_cnt == 1) begin rsp_at = n; got = rsp_rdata; end
            end
            if (req_ready) break;
        end
        if (wr) begin
            chk(n == exp_done, last_rd ? "R8 write ready latency after read"
                                       : "R8 write ready latency", n, exp_done);
            w = get_word(1'b0, int'(a));
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            shadow[int'(a)] = w;
        end else begin
            chk(n == exp_done, "R3 read ready latency", n, exp_done);
            chk(rsp_cnt == 1, "R3 single response strobe", rsp_cnt, 1);
            chk(rsp_at == E_RD + 2, "R3 response latency", rsp_at, E_RD + 2);
            chk(got == (get_word(1'b0, int'(a)) & lane_mask(m)), "R4 R7 read data",
                int'(got), int'(get_word(1'b0, int'(a)) & lane_mask(m)));
        end
        last_rd = !wr;
    endtask

    logic [AW-1:0] addrs [5] = '{20'h00000, 20'h00001, 20'h00002, 20'h5A5A5, 20'hFFFFF};

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n &&
            sram_ble_n && sram_bhe_n && !sram_dq_oe, "R1 pins in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && sram_ce1_n && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 pins after reset", int'(req_ready), 1);

        // Sweep: every address, every mask, read after write and write after read
        for (int i = 0; i < 5; i++) begin
            do_op(1'b1, addrs[i], 16'hA55A ^ 16'(i * 16'h1111), 2'b11, 1'b0, '0);
            for (int m = 0; m < 4; m++) begin
                do_op(1'b1, addrs[i], 16'h3CC3 + 16'(m * 16'h0F01 + i), 2'(m), 1'b0, '0);
                do_op(1'b0, addrs[i], '0, 2'b11, 1'b0, '0);
                do_op(1'b0, addrs[i], '0, 2'(m), 1'b0, '0);
            end
        end

        // Write after write, no turnaround expected
        do_op(1'b1, 20'h00010, 16'h1234, 2'b11, 1'b0, '0);
        do_op(1'b1, 20'h00011, 16'h5678, 2'b01, 1'b0, '0);
        do_op(1'b0, 20'h00011, '0, 2'b11, 1'b0, '0);

        // R2: request raised and dropped while busy must not reach memory
        do_op(1'b1, 20'h00020, 16'hC0DE, 2'b11, 1'b1, 20'h00021);
        do_op(1'b0, 20'h00021, '0, 2'b11, 1'b0, '0);
        chk(get_word(1'b1, 32'h21) == 16'h0000, "R2 busy request ignored",
            int'(get_word(1'b1, 32'h21)), 0);
        do_op(1'b0, 20'h00020, '0, 2'b10, 1'b1, 20'h00022);
        do_op(1'b0, 20'h00022, '0, 2'b11, 1'b0, '0);

        @(negedge clk);
        chk(req_ready && sram_ce1_n && sram_oe_n && sram_we_n && !sram_dq_oe,
            "R10 idle pins at end", int'(req_ready), 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule